// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block owns the refresh side of an asynchronous DRAM interface. After reset it waits out a power-up pause, then drives a fixed number of CAS-before-RAS cycles on its own before it reports the memory as ready. From then on an interval timer marks when a distributed refresh falls due. Due refreshes build up in a saturating backlog counter. While the backlog is non-zero the block raises a request to the access controller. Once that request is granted, the block drives the row and column strobes through one CAS-before-RAS cycle. When the cycle ends it gives a single-cycle done pulse and takes one off the backlog. If the grant stays high and work is still owed, refreshes run back to back.

The same request and grant path also puts the memory into a low-power self-refresh state. The block holds both strobes low for at least a programmed minimum, and longer if the self-refresh request stays up. On release it holds a long precharge, then issues exactly one CAS-before-RAS cycle while it still owns the bus, before it hands the bus back with a done pulse. Any backlog is dropped when self-refresh begins. All times are parameters counted in clock cycles.

Top module: `rfs_scheduler`

## Requirements
- R1: While reset is asserted, ras_n, cas_n and we_n are high, and ref_req, ref_done, init_done and sr_active are low.
- R2: After reset is released, both strobes stay high, and cas_n first falls in the cycle that follows the INIT_WAIT-th rising clock edge.
- R3: The block issues exactly INIT_CBR CAS-before-RAS cycles after the pause. Only then does init_done rise, and it stays high until reset. ref_req and ref_done stay low while init_done is low.
- R4: Every CAS-before-RAS cycle has the same shape. cas_n is low with ras_n high for at least T_CSR cycles before ras_n falls. ras_n stays low for at least T_RAS cycles. ras_n and cas_n rise together. Both then stay high for at least T_RP cycles before cas_n falls again. we_n is high at all times.
- R5: Once init_done is high, a refresh falls due every INTERVAL cycles. The first ref_req is seen INTERVAL+1 cycles after the first cycle with init_done high.
- R6: ref_req stays high in every cycle until it is granted. A grant while ref_req is low starts nothing, and both strobes stay high.
- R7: Each granted refresh ends with a ref_done pulse exactly one cycle long and takes one off the backlog. The backlog saturates at BACKLOG_MAX. A held grant drains exactly BACKLOG_MAX refreshes back to back.
- R8: A high sr_req raises ref_req. When granted, cas_n falls first, then ras_n falls and sr_active goes high. sr_active lasts exactly SR_MIN cycles if sr_req drops early. Otherwise it ends in the cycle after sr_req is seen low.
- R9: After self-refresh, both strobes are high for exactly SR_PRE cycles. Exactly one CAS-before-RAS cycle then follows, ended by one ref_done pulse. The backlog is cleared, so ref_req is low in the cycle after that pulse.
- R10: When a grant arrives, a pending sr_req takes priority over owed refreshes. The granted sequence is self-refresh, with no plain refresh before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Bus grant from the access controller |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| ref_req | output | 1 | Request for the bus (refresh owed or self-refresh wanted) |
| ref_done | output | 1 | One-cycle pulse when a granted sequence is finished |
| init_done | output | 1 | Power-up sequence complete |
| sr_active | output | 1 | Memory is held in self-refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The assertions check the local rules in every cycle. These are the strobe ordering at each edge of ras_n, the request held until grant, the single-cycle done pulse, silence before init_done, and the state of the strobes at the self-refresh exit. Only the bench scenarios can show the counted behaviour. That covers the exact pause length, the number of init cycles, the interval period, saturation of the backlog during a long grant delay, the self-refresh minimum and precharge lengths, and the single catch-up cycle with the backlog cleared afterwards.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_CSET, ST_RLOW, ST_PRE,
    ST_SR_CSET, ST_SR_HOLD, ST_SR_PRE
  } rfs_state_t;

  typedef enum logic [1:0] {K_INIT, K_REF, K_SRX} rfs_kind_t;

  // Saturating up/down step with clear priority.
  function automatic logic [15:0] backlog_next(
    input logic [15:0] cur, input logic inc, input logic dec,
    input logic clr, input logic [15:0] lim);
    logic [15:0] r;
    r = cur;
    if (clr) r = '0;
    else if (inc && !dec) r = (cur >= lim) ? lim : cur + 16'd1;
    else if (dec && !inc) r = (cur == 16'd0) ? 16'd0 : cur - 16'd1;
    return r;
  endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int INTERVAL = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = $clog2(INTERVAL + 1);
  logic [TW-1:0] cnt;

  assign tick = run && (cnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog
  import rfs_pkg::*;
#(
  parameter int BACKLOG_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  input  logic clr,
  output logic pending
);
  localparam int BW = $clog2(BACKLOG_MAX + 1);
  logic [BW-1:0] count_q;

  assign pending = (count_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else count_q <= BW'(backlog_next(16'(count_q), inc, dec, clr, 16'(BACKLOG_MAX)));
  end
endmodule

// File: rtl/rfs_strobe_fsm.sv
module rfs_strobe_fsm
  import rfs_pkg::*;
#(
  parameter int INIT_WAIT = 25000,
  parameter int INIT_CBR  = 8,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 8,
  parameter int T_RP      = 5,
  parameter int SR_MIN    = 12500,
  parameter int SR_PRE    = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  input  logic sr_req,
  input  logic pending,
  output logic ras_n,
  output logic cas_n,
  output logic ref_req,
  output logic done,
  output logic init_done,
  output logic sr_active,
  output logic in_sr,
  output logic sr_start,
  output logic ref_retire
);
  localparam int CW = $clog2(INIT_WAIT + SR_MIN + T_CSR + T_RAS + T_RP + SR_PRE + 2);
  localparam int IW = $clog2(INIT_CBR + 1);

  rfs_state_t    state;
  rfs_kind_t     kind;
  logic [CW-1:0] cnt;
  logic [IW-1:0] init_left;
  logic          init_q;

  // Named internal events
  logic pre_last, grant_take;
  assign pre_last   = (state == ST_PRE) && (cnt == CW'(T_RP - 1));
  assign ref_req    = (state == ST_IDLE) && init_q && (sr_req || pending);
  assign grant_take = ref_req && gnt;
  assign sr_start   = grant_take && sr_req;
  assign done       = pre_last && (kind != K_INIT);
  assign ref_retire = done && (kind == K_REF);
  assign init_done  = init_q;
  assign sr_active  = (state == ST_SR_HOLD);
  assign in_sr      = (state == ST_SR_CSET) || (state == ST_SR_HOLD) || (state == ST_SR_PRE);
  assign ras_n      = !((state == ST_RLOW) || (state == ST_SR_HOLD));
  assign cas_n      = !((state == ST_CSET) || (state == ST_RLOW) ||
                        (state == ST_SR_CSET) || (state == ST_SR_HOLD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_BOOT;
      kind      <= K_INIT;
      cnt       <= '0;
      init_left <= IW'(INIT_CBR);
      init_q    <= 1'b0;
    end else begin
      case (state)
        ST_BOOT:
          if (cnt == CW'(INIT_WAIT - 1)) begin state <= ST_CSET; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        ST_IDLE:
          if (grant_take) begin
            cnt <= '0;
            if (sr_req) state <= ST_SR_CSET;
            else begin state <= ST_CSET; kind <= K_REF; end
          end
        ST_CSET:
          if (cnt == CW'(T_CSR - 1)) begin state <= ST_RLOW; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        ST_RLOW:
          if (cnt == CW'(T_RAS - 1)) begin state <= ST_PRE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        ST_PRE:
          if (pre_last) begin
            cnt <= '0;
            if (kind == K_INIT) begin
              if (init_left == IW'(1)) begin init_q <= 1'b1; state <= ST_IDLE; end
              else begin init_left <= init_left - 1'b1; state <= ST_CSET; end
            end else state <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        ST_SR_CSET:
          if (cnt == CW'(T_CSR - 1)) begin state <= ST_SR_HOLD; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        ST_SR_HOLD:
          if (cnt >= CW'(SR_MIN - 1)) begin
            if (!sr_req) begin state <= ST_SR_PRE; cnt <= '0; end
          end else cnt <= cnt + 1'b1;
        ST_SR_PRE:
          if (cnt == CW'(SR_PRE - 1)) begin state <= ST_CSET; kind <= K_SRX; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfs_scheduler.sv
module rfs_scheduler #(
  parameter int INIT_WAIT   = 25000,
  parameter int INIT_CBR    = 8,
  parameter int INTERVAL    = 1950,
  parameter int BACKLOG_MAX = 4,
  parameter int T_CSR       = 2,
  parameter int T_RAS       = 8,
  parameter int T_RP        = 5,
  parameter int SR_MIN      = 12500,
  parameter int SR_PRE      = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  input  logic sr_req,
  output logic ref_req,
  output logic ref_done,
  output logic init_done,
  output logic sr_active,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  logic due_tick, owed, in_sr, sr_start, ref_retire, timer_run;

  assign timer_run = init_done && !in_sr;
  assign we_n      = 1'b1;

  rfs_interval_timer #(.INTERVAL(INTERVAL)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .tick(due_tick));

  rfs_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) i_backlog (
    .clk(clk), .rst_n(rst_n), .inc(due_tick), .dec(ref_retire),
    .clr(sr_start), .pending(owed));

  rfs_strobe_fsm #(
    .INIT_WAIT(INIT_WAIT), .INIT_CBR(INIT_CBR), .T_CSR(T_CSR), .T_RAS(T_RAS),
    .T_RP(T_RP), .SR_MIN(SR_MIN), .SR_PRE(SR_PRE)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n), .gnt(ref_gnt), .sr_req(sr_req), .pending(owed),
    .ras_n(ras_n), .cas_n(cas_n), .ref_req(ref_req), .done(ref_done),
    .init_done(init_done), .sr_active(sr_active), .in_sr(in_sr),
    .sr_start(sr_start), .ref_retire(ref_retire));
endmodule

// File: rtl/rfs_sched_checker.sv
module rfs_sched_checker (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt,
  input logic sr_req,
  input logic ref_req,
  input logic ref_done,
  input logic init_done,
  input logic sr_active,
  input logic ras_n,
  input logic cas_n
);
  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
  a_r4_strobes_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt && !sr_req) |=> ref_req);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);
  a_r3_quiet_before_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (!ref_req && !ref_done));
  a_r3_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r9_exit_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_active) |-> (ras_n && cas_n && !ref_done));
endmodule

bind rfs_scheduler rfs_sched_checker i_rfs_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sr_req(sr_req),
  .ref_req(ref_req), .ref_done(ref_done), .init_done(init_done),
  .sr_active(sr_active), .ras_n(ras_n), .cas_n(cas_n));

// File: tb/test_rfs_scheduler.sv
`timescale 1ns/1ps
module test_rfs_scheduler;
  localparam int INIT_WAIT = 60, INIT_CBR = 8, INTERVAL = 200, BACKLOG_MAX = 3;
  localparam int T_CSR = 2, T_RAS = 8, T_RP = 5, SR_MIN = 30, SR_PRE = 14;

  logic clk = 0, rst_n = 0, ref_gnt = 0, sr_req = 0;
  logic ref_req, ref_done, init_done, sr_active, ras_n, cas_n, we_n;
  int checks = 0, failures = 0;
  bit mon_on = 0;

  always #4 clk = ~clk;

  rfs_scheduler #(.INIT_WAIT(INIT_WAIT), .INIT_CBR(INIT_CBR), .INTERVAL(INTERVAL),
    .BACKLOG_MAX(BACKLOG_MAX), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP),
    .SR_MIN(SR_MIN), .SR_PRE(SR_PRE)) i_rfs_scheduler (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sr_req(sr_req), .ref_req(ref_req),
    .ref_done(ref_done), .init_done(init_done), .sr_active(sr_active),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit strobes_idle();
    return ras_n && cas_n;
  endfunction

  // Strobe-shape monitor (R4) and one-cycle done monitor (R7)
  int cas_lead = 0, ras_low = 0, both_high = 1000;
  logic p_ras = 1, p_cas = 1, p_done = 0;
  always @(negedge clk) if (mon_on) begin
    if (we_n !== 1'b1) chk(0, "R4 we_n high", int'(we_n), 1);
    if (p_ras && !ras_n) chk(cas_lead >= T_CSR, "R4 cas lead", cas_lead, T_CSR);
    if (!p_ras && ras_n) begin
      chk(ras_low >= T_RAS, "R4 ras low width", ras_low, T_RAS);
      chk(cas_n, "R4 strobes rise together", int'(cas_n), 1);
    end
    if (p_cas && !cas_n) chk(both_high >= T_RP, "R4 precharge", both_high, T_RP);
    if (p_done && ref_done) chk(0, "R7 done one cycle", 2, 1);
    cas_lead  = (!cas_n && ras_n) ? cas_lead + 1 : 0;
    ras_low   = !ras_n ? ras_low + 1 : 0;
    both_high = (ras_n && cas_n) ? both_high + 1 : 0;
    p_ras = ras_n; p_cas = cas_n; p_done = ref_done;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic wait_req(input int lim);
    for (int i = 0; i < lim && !ref_req; i++) @(negedge clk);
  endtask

  initial begin
    int n, cnt, bad, d, dones, falls, h;
    logic pr;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", int'({ras_n, cas_n, we_n}), 7);
    chk(!ref_req && !ref_done && !init_done && !sr_active, "R1 outputs low in reset",
        int'({ref_req, ref_done, init_done, sr_active}), 0);
    rst_n = 1; mon_on = 1;
    // R2 pause length
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (cas_n && n < 1000);
    chk(n == INIT_WAIT, "R2 first cas fall edge", n, INIT_WAIT);
    // R3 init cycles
    cnt = 0; bad = 0; pr = ras_n;
    for (int i = 0; i < 2000 && !init_done; i++) begin
      @(negedge clk);
      if (pr && !ras_n) cnt++;
      if (!init_done && (ref_req || ref_done)) bad++;
      pr = ras_n;
    end
    chk(cnt == INIT_CBR, "R3 init cbr count", cnt, INIT_CBR);
    chk(bad == 0, "R3 no req before init", bad, 0);
    // R5 first interval
    n = 1;
    while (!ref_req && n < 5000) begin @(negedge clk); n++; end
    chk(n == INTERVAL + 1, "R5 first request delay", n, INTERVAL + 1);
    // R6 hold, R7 saturation
    bad = 0;
    for (int i = 0; i < 4 * INTERVAL + 2; i++) begin
      @(negedge clk);
      if (!ref_req || !strobes_idle()) bad++;
    end
    chk(bad == 0, "R6 request held ungranted", bad, 0);
    ref_gnt = 1; dones = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (ref_done) dones++;
    end
    chk(dones == BACKLOG_MAX, "R7 saturated drain count", dones, BACKLOG_MAX);
    chk(!ref_req, "R7 backlog empty after drain", int'(ref_req), 0);
    // R6 grant without request
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!strobes_idle()) bad++;
    end
    chk(bad == 0, "R6 spurious grant ignored", bad, 0);
    ref_gnt = 0;
    // R6/R7 random grant latency
    for (int r = 0; r < 6; r++) begin
      wait_req(3 * INTERVAL);
      chk(ref_req, "R5 periodic request", int'(ref_req), 1);
      d = $urandom_range(0, 40); bad = 0;
      for (int i = 0; i < d; i++) begin
        @(negedge clk);
        if (!ref_req || !strobes_idle()) bad++;
      end
      chk(bad == 0, "R6 held through random delay", bad, 0);
      ref_gnt = 1; n = 0;
      while (!ref_done && n < 60) begin @(negedge clk); n++; end
      chk(ref_done, "R7 done after grant", int'(ref_done), 1);
      chk(n == 1 + T_CSR + T_RAS + T_RP - 1, "R7 done latency", n, T_CSR + T_RAS + T_RP);
      ref_gnt = 0;
      @(negedge clk);
      chk(!ref_done && !ref_req, "R7 single pulse and decrement",
          int'({ref_done, ref_req}), 0);
    end
    // R10/R8/R9 self-refresh with refresh pending, early release
    wait_req(3 * INTERVAL);
    sr_req = 1; ref_gnt = 1;
    @(negedge clk);
    chk(!cas_n && ras_n, "R8 cas falls first", int'({ras_n, cas_n}), 2);
    ref_gnt = 0; dones = 0; n = 0;
    while (!sr_active && n < 50) begin @(negedge clk); n++; if (ref_done) dones++; end
    chk(sr_active && dones == 0, "R10 self-refresh wins over backlog", dones, 0);
    cnt = 0;
    while (sr_active && cnt < 1000) begin
      cnt++;
      if (cnt == 5) sr_req = 0;
      @(negedge clk);
    end
    chk(cnt == SR_MIN, "R8 minimum hold", cnt, SR_MIN);
    n = 0;
    while (cas_n && n < 100) begin n++; @(negedge clk); end
    chk(n == SR_PRE, "R9 exit precharge", n, SR_PRE);
    falls = 0; dones = 0; pr = ras_n;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pr && !ras_n) falls++;
      if (ref_done) dones++;
      pr = ras_n;
    end
    chk(falls == 1 && dones == 1, "R9 one catch-up cycle", falls * 10 + dones, 11);
    chk(!ref_req, "R9 backlog cleared", int'(ref_req), 0);
    // R8 long hold
    sr_req = 1;
    @(negedge clk);
    chk(ref_req, "R8 sr raises request", int'(ref_req), 1);
    ref_gnt = 1;
    n = 0;
    while (!sr_active && n < 50) begin @(negedge clk); n++; end
    ref_gnt = 0;
    h = SR_MIN + 25; cnt = 0;
    while (sr_active && cnt < 1000) begin
      cnt++;
      if (cnt == h) sr_req = 0;
      @(negedge clk);
    end
    chk(cnt == h, "R8 hold follows request", cnt, h);
    n = 0;
    while (!ref_done && n < 100) begin @(negedge clk); n++; end
    chk(ref_done, "R9 done after long hold", int'(ref_done), 1);
    @(negedge clk);
    chk(!ref_req && strobes_idle(), "R9 quiet after exit", int'(ref_req), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule